// File: doc/BRIEF.md
# Bidirectional Dual-Clock FIFO Pair with Port-A Threshold Flags

This block joins two independently clocked ports through a pair of first-in first-out buffers that carry data in opposite directions. The forward buffer accepts words on the A side and delivers them on the B side. The return buffer accepts words on the B side and delivers them on the A side. Each port has the same four control pins: an active-low select, a direction pin, a side-channel select and an enable. These pins decode into a write or a read of the buffer that belongs to the chosen direction. A word is accepted only when the side-channel select is low.

Both threshold flags are reported in the A clock domain, whichever port caused the change. The first is an active-low near-empty flag for the return buffer. The second is an active-low near-full flag for the forward buffer. Each flag has its own static threshold input. Pointers cross between the domains as Gray code through two-stage synchronizers. An action on the A side therefore moves a flag at once. An action on the B side releases a flag only after the synchronizer delay.

Top module: `bidir_fifo_pair`

## Requirements
- R1: A forward-buffer write happens on a rising `clk_a` edge when `a_select_n`=0, `a_dir`=1, `a_mbox`=0 and `a_en`=1. A forward-buffer read happens on a rising `clk_b` edge when `b_select_n`=0, `b_dir`=1, `b_mbox`=0 and `b_en`=1. Words leave in the order they were written.
- R2: A return-buffer write happens on a rising `clk_b` edge when `b_dir`=0 and the other three pins are as in R1. A return-buffer read happens on a rising `clk_a` edge when `a_dir`=0 and the other three pins are as in R1. Words leave in order.
- R3: A buffer holding 2^ADDR_W words raises its write-side full flag. It then ignores further writes, and its contents and order are unchanged.
- R4: An empty buffer raises its read-side empty flag. A read of an empty buffer is ignored: the read-data output keeps its value and no pointer moves.
- R5: No transfer takes place while the select is high, the side-channel select is high or the enable is low.
- R6: `a_fifo2_almost_empty_n` is 0 while the return buffer, as seen from `clk_a`, holds `aempty_offset` words or fewer. It is 1 once the buffer holds one word more than that.
- R7: `a_fifo1_almost_full_n` is 0 while the forward buffer, as seen from `clk_a`, holds at least 2^ADDR_W − `afull_offset` words. It is 1 below that level.
- R8: An A-side write or read that moves a flag into its active level shows on that flag right after the same `clk_a` edge.
- R9: A B-side action that releases a flag does not change the flag before the next rising `clk_a` edge. The flag goes high no later than the third rising `clk_a` edge after the B edge. A Gray pointer changes by at most one bit per cycle.
- R10: While `rst_n` is low, both buffers are empty. In that state `a_fifo2_almost_empty_n`=0, `a_fifo1_almost_full_n`=1, both full flags are 0, both empty flags are 1 and both read-data outputs are 0.
- R11: Read data is registered. It changes on the clock edge that performs a valid read and holds until the next valid read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock; both threshold flags are synchronous to it |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-low reset for both buffers |
| a_select_n | input | 1 | Port A select, active low |
| a_dir | input | 1 | Port A direction: 1 writes forward buffer, 0 reads return buffer |
| a_mbox | input | 1 | Port A side-channel select; 1 blocks buffer access |
| a_en | input | 1 | Port A transfer enable |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A registered read data (return buffer) |
| a_fifo1_full | output | 1 | Forward buffer full, `clk_a` domain |
| a_fifo2_empty | output | 1 | Return buffer empty, `clk_a` domain |
| a_fifo2_almost_empty_n | output | 1 | Return buffer near-empty, active low |
| a_fifo1_almost_full_n | output | 1 | Forward buffer near-full, active low |
| b_select_n | input | 1 | Port B select, active low |
| b_dir | input | 1 | Port B direction: 1 reads forward buffer, 0 writes return buffer |
| b_mbox | input | 1 | Port B side-channel select; 1 blocks buffer access |
| b_en | input | 1 | Port B transfer enable |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B registered read data (forward buffer) |
| b_fifo1_empty | output | 1 | Forward buffer empty, `clk_b` domain |
| b_fifo2_full | output | 1 | Return buffer full, `clk_b` domain |
| aempty_offset | input | ADDR_W+1 | Static near-empty threshold for the return buffer |
| afull_offset | input | ADDR_W+1 | Static near-full threshold for the forward buffer |

## Verification
On every cycle the assertions check four things:
- a full buffer never advances its write pointer, and an empty buffer never advances its read pointer or changes its read data;
- the level seen by a domain never exceeds the depth;
- a Gray pointer steps by at most one bit;
- a full or empty flag always comes with the matching active threshold flag.

Only the bench scenarios can show the rest: ordered delivery across the two clocks, pin decoding that blocks unwanted transfers, the exact threshold crossings, and the timing of a flag release from the B side, which must arrive neither early nor more than a few `clk_a` edges late.

// File: rtl/bfifo_pkg.sv
`timescale 1ns/1ps
package bfifo_pkg;

    // Decoded access strobes of one port: the operation selected by
    // direction=1 and the one selected by direction=0.
    typedef struct packed {
        logic dir_hi;
        logic dir_lo;
    } port_strobe_t;

endpackage

// File: rtl/port_decode.sv
`timescale 1ns/1ps
module port_decode
    import bfifo_pkg::*;
(
    input  logic         select_n,
    input  logic         dir,
    input  logic         mbox,
    input  logic         en,
    output port_strobe_t strobe
);

    logic access_ok;

    always_comb begin
        access_ok     = !select_n && !mbox && en;
        strobe.dir_hi = access_ok && dir;
        strobe.dir_lo = access_ok && !dir;
    end

endmodule

// File: rtl/gray_sync.sv
`timescale 1ns/1ps
module gray_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.s1 = gray_in;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    // Gray to binary: bit i is the parity of all gray bits at or above i.
    always_comb begin
        for (int i = 0; i < W; i++) begin
            bin_out[i] = ^(sync_q.s2 >> i);
        end
    end

endmodule

// File: rtl/async_fifo_core.sv
`timescale 1ns/1ps
module async_fifo_core #(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 8
) (
    input  logic              rst_n,
    // write domain
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic              full,
    output logic [ADDR_W:0]   wr_level,
    // read domain
    input  logic              rd_clk,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    output logic              empty,
    output logic [ADDR_W:0]   rd_level
);

    localparam int PTR_W = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [PTR_W-1:0] bin;
        logic [PTR_W-1:0] gray;
    } wr_state_t;

    typedef struct packed {
        logic [PTR_W-1:0]  bin;
        logic [PTR_W-1:0]  gray;
        logic [DATA_W-1:0] data;
    } rd_state_t;

    wr_state_t wr_d, wr_q;
    rd_state_t rd_d, rd_q;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  rptr_in_wr;
    logic [PTR_W-1:0]  wptr_in_rd;
    logic              push;
    logic              pop;

    gray_sync #(.W(PTR_W)) u_rptr_sync (
        .clk     (wr_clk),
        .rst_n   (rst_n),
        .gray_in (rd_q.gray),
        .bin_out (rptr_in_wr)
    );

    gray_sync #(.W(PTR_W)) u_wptr_sync (
        .clk     (rd_clk),
        .rst_n   (rst_n),
        .gray_in (wr_q.gray),
        .bin_out (wptr_in_rd)
    );

    // ---------------- write domain ----------------
    always_comb begin
        wr_level  = wr_q.bin - rptr_in_wr;
        full      = (wr_level == PTR_W'(DEPTH));
        push      = wr_en && !full;
        wr_d      = wr_q;
        wr_d.bin  = wr_q.bin + PTR_W'(push);
        wr_d.gray = wr_d.bin ^ (wr_d.bin >> 1);
    end

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) wr_q <= '0;
        else        wr_q <= wr_d;
    end

    always_ff @(posedge wr_clk) begin
        if (push) mem[wr_q.bin[ADDR_W-1:0]] <= wdata;
    end

    // ---------------- read domain ----------------
    always_comb begin
        rd_level  = wptr_in_rd - rd_q.bin;
        empty     = (rd_level == '0);
        pop       = rd_en && !empty;
        rd_d      = rd_q;
        rd_d.bin  = rd_q.bin + PTR_W'(pop);
        rd_d.gray = rd_d.bin ^ (rd_d.bin >> 1);
        if (pop) rd_d.data = mem[rd_q.bin[ADDR_W-1:0]];
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rdata = rd_q.data;

    // ---------------- assertions ----------------
    a_r3_no_overflow: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wr_en && full) |=> $stable(wr_q.bin));

    a_r3_level_bound: assert property (@(posedge wr_clk) disable iff (!rst_n)
        wr_level <= PTR_W'(DEPTH));

    a_r4_no_underflow: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_en && empty) |=> ($stable(rd_q.bin) && $stable(rdata)));

    a_r9_wgray_step: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $countones(wr_q.gray ^ $past(wr_q.gray)) <= 1);

    a_r9_rgray_step: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $countones(rd_q.gray ^ $past(rd_q.gray)) <= 1);

endmodule

// File: rtl/bidir_fifo_pair.sv
`timescale 1ns/1ps
module bidir_fifo_pair
    import bfifo_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 8
) (
    input  logic              clk_a,
    input  logic              clk_b,
    input  logic              rst_n,
    input  logic              a_select_n,
    input  logic              a_dir,
    input  logic              a_mbox,
    input  logic              a_en,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_fifo1_full,
    output logic              a_fifo2_empty,
    output logic              a_fifo2_almost_empty_n,
    output logic              a_fifo1_almost_full_n,
    input  logic              b_select_n,
    input  logic              b_dir,
    input  logic              b_mbox,
    input  logic              b_en,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_fifo1_empty,
    output logic              b_fifo2_full,
    input  logic [ADDR_W:0]   aempty_offset,
    input  logic [ADDR_W:0]   afull_offset
);

    localparam int PTR_W = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    port_strobe_t a_strobe, b_strobe;
    logic [ADDR_W:0] fwd_wr_level, fwd_rd_level;
    logic [ADDR_W:0] ret_wr_level, ret_rd_level;
    logic [ADDR_W:0] afull_mark;

    port_decode u_dec_a (
        .select_n (a_select_n),
        .dir      (a_dir),
        .mbox     (a_mbox),
        .en       (a_en),
        .strobe   (a_strobe)
    );

    port_decode u_dec_b (
        .select_n (b_select_n),
        .dir      (b_dir),
        .mbox     (b_mbox),
        .en       (b_en),
        .strobe   (b_strobe)
    );

    // forward buffer: written on A, read on B
    async_fifo_core #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_fwd (
        .rst_n    (rst_n),
        .wr_clk   (clk_a),
        .wr_en    (a_strobe.dir_hi),
        .wdata    (a_wdata),
        .full     (a_fifo1_full),
        .wr_level (fwd_wr_level),
        .rd_clk   (clk_b),
        .rd_en    (b_strobe.dir_hi),
        .rdata    (b_rdata),
        .empty    (b_fifo1_empty),
        .rd_level (fwd_rd_level)
    );

    // return buffer: written on B, read on A
    async_fifo_core #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ret (
        .rst_n    (rst_n),
        .wr_clk   (clk_b),
        .wr_en    (b_strobe.dir_lo),
        .wdata    (b_wdata),
        .full     (b_fifo2_full),
        .wr_level (ret_wr_level),
        .rd_clk   (clk_a),
        .rd_en    (a_strobe.dir_lo),
        .rdata    (a_rdata),
        .empty    (a_fifo2_empty),
        .rd_level (ret_rd_level)
    );

    // Both flags derive from registers clocked by clk_a only.
    always_comb begin
        afull_mark             = PTR_W'(DEPTH) - afull_offset;
        a_fifo1_almost_full_n  = !(fwd_wr_level >= afull_mark);
        a_fifo2_almost_empty_n = !(ret_rd_level <= aempty_offset);
    end

    a_r7_full_implies_afull: assert property (@(posedge clk_a) disable iff (!rst_n)
        a_fifo1_full |-> !a_fifo1_almost_full_n);

    a_r6_empty_implies_aempty: assert property (@(posedge clk_a) disable iff (!rst_n)
        a_fifo2_empty |-> !a_fifo2_almost_empty_n);

endmodule

// File: tb/bidir_fifo_pair_tb.sv
`timescale 1ns/1ps
module bidir_fifo_pair_tb;

    localparam int DW    = 36;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam int XOFF  = 3;
    localparam int YOFF  = 4;

    logic clk_a = 1'b0;
    logic clk_b = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk_a = ~clk_a;
    always #7 clk_b = ~clk_b;

    logic a_select_n = 1'b1, a_dir = 1'b0, a_mbox = 1'b0, a_en = 1'b0;
    logic b_select_n = 1'b1, b_dir = 1'b0, b_mbox = 1'b0, b_en = 1'b0;
    logic [DW-1:0] a_wdata = '0, b_wdata = '0;
    logic [DW-1:0] a_rdata, b_rdata;
    logic a_fifo1_full, a_fifo2_empty, a_aempty_n, a_afull_n;
    logic b_fifo1_empty, b_fifo2_full;

    bidir_fifo_pair #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
        .clk_a (clk_a), .clk_b (clk_b), .rst_n (rst_n),
        .a_select_n (a_select_n), .a_dir (a_dir), .a_mbox (a_mbox), .a_en (a_en),
        .a_wdata (a_wdata), .a_rdata (a_rdata),
        .a_fifo1_full (a_fifo1_full), .a_fifo2_empty (a_fifo2_empty),
        .a_fifo2_almost_empty_n (a_aempty_n), .a_fifo1_almost_full_n (a_afull_n),
        .b_select_n (b_select_n), .b_dir (b_dir), .b_mbox (b_mbox), .b_en (b_en),
        .b_wdata (b_wdata), .b_rdata (b_rdata),
        .b_fifo1_empty (b_fifo1_empty), .b_fifo2_full (b_fifo2_full),
        .aempty_offset ((AW+1)'(XOFF)), .afull_offset ((AW+1)'(YOFF))
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [DW-1:0] q1[$];
    logic [DW-1:0] q2[$];
    int cnt1 = 0;
    int cnt2 = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk_b);
        repeat (4) @(negedge clk_a);
    endtask

    // driver: port A forward write, expected item pushed to the scoreboard
    task automatic a_write(input logic [DW-1:0] d);
        @(negedge clk_a);
        a_select_n = 0; a_dir = 1; a_mbox = 0; a_en = 1; a_wdata = d;
        @(posedge clk_a);
        if (cnt1 < DEPTH) begin q1.push_back(d); cnt1++; end
        @(negedge clk_a);
        a_select_n = 1; a_en = 0;
    endtask

    task automatic b_write(input logic [DW-1:0] d);
        @(negedge clk_b);
        b_select_n = 0; b_dir = 0; b_mbox = 0; b_en = 1; b_wdata = d;
        @(posedge clk_b);
        if (cnt2 < DEPTH) begin q2.push_back(d); cnt2++; end
        @(negedge clk_b);
        b_select_n = 1; b_en = 0;
    endtask

    // monitor: port B forward read compared against the scoreboard
    task automatic b_read(input string req);
        logic [DW-1:0] prev;
        logic [DW-1:0] exp;
        @(negedge clk_b);
        prev = b_rdata;
        b_select_n = 0; b_dir = 1; b_mbox = 0; b_en = 1;
        #1;
        chk(b_rdata == prev, "R11 rdata held before read edge", 64'(b_rdata), 64'(prev));
        @(posedge clk_b);
        @(negedge clk_b);
        b_select_n = 1; b_en = 0;
        if (cnt1 > 0) begin exp = q1.pop_front(); cnt1--; end
        else exp = prev;
        chk(b_rdata == exp, req, 64'(b_rdata), 64'(exp));
    endtask

    task automatic a_read(input string req);
        logic [DW-1:0] prev;
        logic [DW-1:0] exp;
        @(negedge clk_a);
        prev = a_rdata;
        a_select_n = 0; a_dir = 0; a_mbox = 0; a_en = 1;
        @(posedge clk_a);
        @(negedge clk_a);
        a_select_n = 1; a_en = 0;
        if (cnt2 > 0) begin exp = q2.pop_front(); cnt2--; end
        else exp = prev;
        chk(a_rdata == exp, req, 64'(a_rdata), 64'(exp));
    endtask

    initial begin
        repeat (100000) @(posedge clk_a);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk_a);
        // R10 reset state
        chk(a_aempty_n == 0, "R10 almost-empty at reset", 64'(a_aempty_n), 0);
        chk(a_afull_n == 1, "R10 almost-full at reset", 64'(a_afull_n), 1);
        chk(a_fifo1_full == 0 && b_fifo2_full == 0, "R10 full flags", 64'({a_fifo1_full, b_fifo2_full}), 0);
        chk(b_fifo1_empty && a_fifo2_empty, "R10 empty flags", 64'({b_fifo1_empty, a_fifo2_empty}), 3);
        chk(a_rdata == 0 && b_rdata == 0, "R10 read data", 64'(a_rdata ^ b_rdata), 0);
        rst_n = 1;
        settle();

        // R1 forward path in order
        for (int i = 0; i < 5; i++) a_write(36'h100 + 36'(i));
        settle();
        for (int i = 0; i < 5; i++) b_read("R1 forward data order");
        settle();
        chk(b_fifo1_empty == 1, "R1 forward drained", 64'(b_fifo1_empty), 1);

        // R5 blocked accesses
        @(negedge clk_a);
        a_dir = 1; a_wdata = 36'hDEAD;
        a_select_n = 1; a_mbox = 0; a_en = 1; @(negedge clk_a);
        a_select_n = 0; a_mbox = 1; a_en = 1; @(negedge clk_a);
        a_select_n = 0; a_mbox = 0; a_en = 0; @(negedge clk_a);
        a_select_n = 1; a_mbox = 0;
        @(negedge clk_b);
        b_dir = 0; b_wdata = 36'hBEEF;
        b_select_n = 1; b_mbox = 0; b_en = 1; @(negedge clk_b);
        b_select_n = 0; b_mbox = 1; b_en = 1; @(negedge clk_b);
        b_select_n = 0; b_mbox = 0; b_en = 0; @(negedge clk_b);
        b_select_n = 1; b_mbox = 0;
        settle();
        chk(b_fifo1_empty == 1, "R5 port A blocked write", 64'(b_fifo1_empty), 1);
        chk(a_fifo2_empty == 1, "R5 port B blocked write", 64'(a_fifo2_empty), 1);
        chk(a_afull_n == 1, "R5 almost-full untouched", 64'(a_afull_n), 1);

        // R2 / R6 return path and near-empty threshold
        for (int i = 0; i < XOFF; i++) begin
            b_write(36'h200 + 36'(i));
            settle();
            chk(a_aempty_n == 0, "R6 at or below threshold", 64'(a_aempty_n), 0);
        end
        b_write(36'h2FF);
        @(negedge clk_a);
        chk(a_aempty_n == 0, "R9 no early release of almost-empty", 64'(a_aempty_n), 0);
        repeat (4) @(negedge clk_a);
        chk(a_aempty_n == 1, "R9 R6 almost-empty released", 64'(a_aempty_n), 1);
        a_read("R2 return data order");
        chk(a_aempty_n == 0, "R8 almost-empty set by A read", 64'(a_aempty_n), 0);
        for (int i = 0; i < XOFF; i++) a_read("R2 return data order");
        chk(a_fifo2_empty == 1, "R4 return empty", 64'(a_fifo2_empty), 1);
        a_read("R4 empty read keeps data");
        b_write(36'h2AA);
        settle();
        a_read("R4 R2 read after empty read");

        // R7 / R8 / R9 forward near-full threshold
        for (int i = 0; i < DEPTH - YOFF - 1; i++) a_write(36'h300 + 36'(i));
        @(negedge clk_a);
        chk(a_afull_n == 1, "R7 below threshold", 64'(a_afull_n), 1);
        a_write(36'h3F0);
        chk(a_afull_n == 0, "R8 R7 almost-full set by A write", 64'(a_afull_n), 0);
        settle();
        b_read("R1 forward data order");
        @(negedge clk_a);
        chk(a_afull_n == 0, "R9 no early release of almost-full", 64'(a_afull_n), 0);
        repeat (4) @(negedge clk_a);
        chk(a_afull_n == 1, "R9 R7 almost-full released", 64'(a_afull_n), 1);

        // R3 fill to full, overflow ignored
        while (cnt1 < DEPTH) a_write(36'h400 + 36'(cnt1));
        @(negedge clk_a);
        chk(a_fifo1_full == 1, "R3 full flag", 64'(a_fifo1_full), 1);
        a_write(36'hBAD);
        settle();
        chk(a_fifo1_full == 1, "R3 still full after overflow", 64'(a_fifo1_full), 1);
        while (cnt1 > 0) b_read("R3 contents intact after overflow");
        settle();
        chk(b_fifo1_empty == 1, "R4 forward empty", 64'(b_fifo1_empty), 1);
        b_read("R4 forward empty read keeps data");

        summary();
        $finish;
    end

endmodule